// File: doc/BRIEF.md
# Reference Loss Detector

This block watches one reference clock input that nominally pulses at 8 kHz (one edge pair every 125 µs). It raises an active-high loss flag when edges stop arriving, and it drops the flag again soon after edges come back. The reference is asynchronous to the system clock. The block passes it through a synchronizer and detects both rising and falling edges. Time is cut into fixed windows of `TICK_CYCLES` system clocks. At each window boundary the block decides whether the window that just ended saw any activity. One instance serves each reference, and the flag feeds the mode and alarm logic downstream.

A state machine with three states makes the decision. `ST_LOST` drives the flag high and is the state out of reset. `ST_LOCKED` holds the flag low. `ST_SUSPECT` also holds the flag low, and it counts consecutive empty windows. The transitions are:
- `LOST->LOCKED` at a window boundary when the window saw activity.
- `LOCKED->SUSPECT` at a boundary when the window was empty, or `LOCKED->LOST` directly when `MISS_WINDOWS` is 1.
- `SUSPECT->LOCKED` at a boundary when the window saw activity.
- `SUSPECT->LOST` when the count of empty windows reaches `MISS_WINDOWS`.

With a 200 MHz clock, a 2 ms window and `MISS_WINDOWS`=1, the flag asserts between 2 ms and 4 ms after the last edge. It clears no more than one window plus a few clocks after the first new edge.

Top module: `refloss_detector`

## Requirements
- R1: The flag `ref_lost` is 1 while reset is applied and after it. It stays 1 until a window that contained activity has ended. A reference held at a constant level, either 0 or 1, across the release of reset is not activity.
- R2: Either edge of the reference counts as activity, rising or falling. This holds for a pulse of either polarity lasting at least two clock periods, so a single narrow pulse clears a lost flag.
- R3: The flag falls at the end of the first window that contained activity. This happens no later than `TICK_CYCLES+SYNC_STAGES+4` clocks after the first edge.
- R4: While every window contains activity, the flag stays 0.
- R5: The flag rises after `MISS_WINDOWS` consecutive empty windows. This is no sooner than `MISS_WINDOWS*TICK_CYCLES` clocks and no later than `(MISS_WINDOWS+1)*TICK_CYCLES+SYNC_STAGES+4` clocks after the last edge. It applies whether the reference stops high or low.
- R6: A gap of fewer than `MISS_WINDOWS*TICK_CYCLES` clocks between edges never raises the flag.
- R7: Outside reset, the flag changes only at window boundaries. Windows restart at the release of reset and are exactly `TICK_CYCLES` clocks long, so every flag change falls a whole number of windows after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Asynchronous reference pulse train |
| ref_lost | output | 1 | Loss-of-reference flag, 1 = alarm |

## Verification
The checks assume two things about the reference. First, every level it holds lasts at least two system clocks, so that the synchronizer captures each pulse. Second, reset is released with the reference quiet for a few clocks. The bench changes `ref_in` only on falling clock edges. Its narrowest pulses last exactly two clocks, of both polarities, and all its gaps are whole numbers of clocks. The window-alignment check on each flag change relies on the window counter starting at the release of reset, which the bench records.

// File: rtl/refloss_pkg.sv
package refloss_pkg;

    typedef enum logic [1:0] {
        ST_LOST    = 2'd0,
        ST_LOCKED  = 2'd1,
        ST_SUSPECT = 2'd2
    } mon_state_e;

endpackage

// File: rtl/refloss_edge_sync.sv
module refloss_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic edge_o
);
    localparam int FILL   = STAGES + 1;
    localparam int FILL_W = $clog2(FILL + 1);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic [FILL_W-1:0] fill_q;
    logic              armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
            fill_q  <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
            prev_q  <= chain_q[STAGES-1];
            if (!armed)
                fill_q <= fill_q + 1'b1;
        end
    end

    assign armed  = (fill_q == FILL_W'(FILL));
    assign edge_o = armed && (chain_q[STAGES-1] != prev_q);

endmodule

// File: rtl/refloss_window_tick.sv
module refloss_window_tick #(
    parameter int TICK_CYCLES = 400000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);

    generate
        if (TICK_CYCLES > 1) begin : g_tick_chk
            assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o)
                else $error("window tick lasted more than one cycle");
        end
    endgenerate

endmodule

// File: rtl/refloss_fsm.sv
module refloss_fsm
    import refloss_pkg::*;
#(
    parameter int MISS_WINDOWS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic edge_i,
    output logic lost_o
);
    localparam int MISS_W = $clog2(MISS_WINDOWS + 1);

    mon_state_e        state_q, state_d;
    logic [MISS_W-1:0] miss_q;
    logic              seen_q;
    logic              win_act;

    assign win_act = seen_q || edge_i;

    // activity latch for the window in progress
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seen_q <= 1'b0;
        else if (tick_i)
            seen_q <= 1'b0;
        else if (edge_i)
            seen_q <= 1'b1;
    end

    // empty-window counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            miss_q <= '0;
        else if (tick_i) begin
            if (win_act || state_q == ST_LOST)
                miss_q <= '0;
            else if (int'(miss_q) < MISS_WINDOWS)
                miss_q <= miss_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOST: begin
                if (tick_i && win_act)
                    state_d = ST_LOCKED;
            end
            ST_LOCKED: begin
                if (tick_i && !win_act)
                    state_d = (MISS_WINDOWS <= 1) ? ST_LOST : ST_SUSPECT;
            end
            ST_SUSPECT: begin
                if (tick_i) begin
                    if (win_act)
                        state_d = ST_LOCKED;
                    else if (int'(miss_q) + 1 >= MISS_WINDOWS)
                        state_d = ST_LOST;
                end
            end
            default: state_d = ST_LOST;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_LOST;
        else
            state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lost_o <= 1'b1;
        else
            lost_o <= (state_d == ST_LOST);
    end

    assert_flag_on_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_o != $past(lost_o)) |-> $past(tick_i))
        else $error("flag moved off a window boundary");

    assert_clear_after_activity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lost_o) |-> $past(win_act))
        else $error("flag cleared after an empty window");

    assert_busy_window_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && win_act) |=> !lost_o)
        else $error("flag high after an active window");

    assert_rise_after_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost_o) |-> $past(!win_act))
        else $error("flag rose after an active window");

    assert_miss_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(miss_q) <= MISS_WINDOWS)
        else $error("empty-window count overran");

endmodule

// File: rtl/refloss_detector.sv
module refloss_detector #(
    parameter int TICK_CYCLES  = 400000,
    parameter int MISS_WINDOWS = 1,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic ref_lost
);
    logic ref_edge;
    logic win_tick;

    refloss_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ref_in),
        .edge_o   (ref_edge)
    );

    refloss_window_tick #(
        .TICK_CYCLES (TICK_CYCLES)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (win_tick)
    );

    refloss_fsm #(
        .MISS_WINDOWS (MISS_WINDOWS)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (win_tick),
        .edge_i (ref_edge),
        .lost_o (ref_lost)
    );

endmodule

// File: tb/refloss_detector_tb.sv
module refloss_detector_tb;

    localparam int T  = 40;
    localparam int M  = 2;
    localparam int SS = 2;
    localparam int SLACK = SS + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic ref_lost;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int rel_cyc = 0;
    int last_edge = 0;

    typedef struct {
        logic  lvl;
        int    lo;
        int    hi;
        bit    aligned;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    refloss_detector #(
        .TICK_CYCLES  (T),
        .MISS_WINDOWS (M),
        .SYNC_STAGES  (SS)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_in   (ref_in),
        .ref_lost (ref_lost)
    );

    task automatic expect_change(input logic lvl, input int lo, input int hi,
                                 input bit aligned, input string tag);
        exp_t e;
        e.lvl = lvl; e.lo = lo; e.hi = hi; e.aligned = aligned; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic check_flag(input logic exp, input string tag);
        checks++;
        if (ref_lost !== exp) begin
            failures++;
            $display("FAIL %s: ref_lost actual=%b expected=%b", tag, ref_lost, exp);
        end
    endtask

    task automatic check_drained(input string tag);
        checks++;
        if (sb_q.size() != 0) begin
            failures++;
            $display("FAIL %s: pending flag changes actual=%0d expected=0", tag, sb_q.size());
            sb_q.delete();
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // n pulses: level flips away from idle for w cycles, period p
    task automatic pulses(input int n, input int p, input int w, input logic idl);
        for (int i = 0; i < n; i++) begin
            ref_in = ~idl;
            idle(w);
            ref_in = idl;
            last_edge = cyc;
            idle(p - w);
        end
    endtask

    // monitor: compares each flag change with the scoreboard
    initial begin
        logic prev_flag;
        exp_t e;
        prev_flag = 1'b1;
        forever begin
            @(negedge clk);
            if (ref_lost !== prev_flag) begin
                prev_flag = ref_lost;
                checks++;
                if (sb_q.size() == 0) begin
                    failures++;
                    $display("FAIL R4/R6: unexpected flag change actual=%b expected=%b at cycle %0d",
                             ref_lost, ~ref_lost, cyc);
                end else begin
                    e = sb_q.pop_front();
                    if (ref_lost !== e.lvl || cyc < e.lo || cyc > e.hi) begin
                        failures++;
                        $display("FAIL %s: flag=%b at cycle %0d expected=%b within [%0d,%0d]",
                                 e.tag, ref_lost, cyc, e.lvl, e.lo, e.hi);
                    end
                    if (e.aligned) begin
                        checks++;
                        if (((cyc - rel_cyc) % T) != 0) begin
                            failures++;
                            $display("FAIL R7: change offset actual=%0d expected=0 (mod %0d)",
                                     (cyc - rel_cyc) % T, T);
                        end
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: cycles actual=150000 expected=fewer");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        idle(5);
        check_flag(1'b1, "R1 during reset");
        rst_n = 1'b1;
        rel_cyc = cyc;
        idle(3 * T);
        check_flag(1'b1, "R1 quiet after reset");

        // R3 + R2: narrow positive pulses start, flag clears
        expect_change(1'b0, cyc, cyc + T + SLACK, 1'b1, "R3 clear latency");
        pulses(30, 16, 2, 1'b0);
        check_flag(1'b0, "R4 steady pulses");
        check_drained("R3 clear seen");

        // R5: reference stops low
        expect_change(1'b1, last_edge + M * T, last_edge + (M + 1) * T + SLACK, 1'b1,
                      "R5 loss, stopped low");
        idle((M + 1) * T + 20);
        check_flag(1'b1, "R5 held low");
        check_drained("R5 low loss seen");

        // R2/R5: one rising edge, then stuck high
        expect_change(1'b0, cyc, cyc + T + SLACK, 1'b1, "R2 single rising edge");
        ref_in = 1'b1;
        last_edge = cyc;
        expect_change(1'b1, last_edge + M * T, last_edge + (M + 1) * T + SLACK, 1'b1,
                      "R5 loss, stopped high");
        idle((M + 2) * T + 20);
        check_flag(1'b1, "R5 held high");
        check_drained("R5 high loss seen");

        // R2: single narrow negative pulse
        expect_change(1'b0, cyc, cyc + T + SLACK, 1'b1, "R2 narrow negative pulse");
        pulses(1, 2, 2, 1'b1);
        expect_change(1'b1, last_edge + M * T, last_edge + (M + 1) * T + SLACK, 1'b1,
                      "R5 loss after lone pulse");
        idle((M + 2) * T + 20);
        check_drained("R2 lone pulse seen");

        // R6: gaps shorter than M windows keep the flag low
        expect_change(1'b0, cyc, cyc + T + SLACK, 1'b1, "R3 clear before gaps");
        pulses(10, 16, 2, 1'b1);
        for (int g = 0; g < 5; g++)
            pulses(1, M * T - 14, 2, 1'b1);
        pulses(5, 16, 2, 1'b1);
        check_flag(1'b0, "R6 short gaps");
        check_drained("R6 only the clear seen");

        // R1: reset mid-run with reference idle high
        expect_change(1'b1, cyc, cyc + 1, 1'b0, "R1 reset forces alarm");
        rst_n = 1'b0;
        idle(2);
        check_flag(1'b1, "R1 in reset");
        rst_n = 1'b1;
        rel_cyc = cyc;
        idle(3 * T);
        check_flag(1'b1, "R1 constant high level is no activity");
        check_drained("R1 reset change seen");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule